// File: doc/BRIEF.md
# Exposed Internal Register Execute Unit

This block is the back half of a two-stage processor whose stage latches are visible to software. Each instruction word arrives already decoded into a bundle of independent effects. In one cycle the bundle may read two general registers, write one, run an ALU operation, start a multiply, issue a data memory access, form an immediate, compute a branch target, save the sequential address and copy a value into a copy register. All of these effects work on the same set of ten internal registers.

There is no forwarding and no comparison of register numbers. An internal register changes only when an effect in the current instruction names it. The unit holds the whole instruction back in one case: the instruction consumes a value that does not exist yet, either a multiply still in progress or a load whose data has not returned. A held-back instruction commits nothing, and the same bundle is presented again on the next cycle. The fetch stage uses the target and sequential registers, which are exported for that purpose. Data memory sees a single request port and returns load data on a separate response strobe.

Top module: `exposed_exec_unit`

## Requirements
- R1: After reset all ten internal registers, `tgtOut` and `seqOut` are zero, `stall` is low, and no memory request is made while `instValid` is low.
- R2: A read effect on port A or port B loads the 32-entry register file entry it names into the first or second source register. A register file write takes effect at the clock edge. A read of the same entry in the same cycle as the write returns the old contents.
- R3: An internal register, `tgtOut` and `seqOut` keep their values for any number of cycles in which no committed effect targets them.
- R4: ALU operation codes: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left by B[4:0], 6 logical shift right by B[4:0], 7 signed less-than (result 1 or 0). When `aluToRes2` is 0 the result goes to the ALU-result register; when it is 1 the result goes to the second result register.
- R5: Immediate form 0 sign-extends `immVal[6:0]` into the sign-extend register. Form 1 replaces its low 16 bits with `immVal`. Form 2 replaces its high 16 bits with `immVal`. In forms 1 and 2 the other half is kept.
- R6: The target effect writes `pcIn` plus the sign-extend register into the target register. The sequential effect writes `pcIn + 4` into the sequential register.
- R7: The copy effect writes the selected internal register into copy register 0 (`cpyDst`=0) or copy register 1 (`cpyDst`=1).
- R8: Every effect reads the internal register values from the start of the cycle. A register written by one effect in the same instruction is seen by the other effects with its old value.
- R9: A multiply returns the low 32 bits of the product of its two operands and writes them to the second result register 32 cycles after issue. While the multiply runs, an instruction that reads the second result register, writes it from the ALU, or starts another multiply raises `stall`. Other instructions proceed without a stall.
- R10: A load raises `memReq` with `memWe` low and `memAddr` set to the selected register. From then until the edge at which `ldRespValid` delivers the data into the load-value register, any instruction that reads the load-value register raises `stall`.
- R11: A stalled instruction commits nothing. It makes no memory request, no register file write and no change to any internal register. If it is withdrawn, it leaves no trace.
- R12: Operand selector codes: 0 source 1, 1 source 2, 2 load value, 3 sign extend, 4 ALU result, 5 second result, 6 target, 7 sequential, 8 copy 0, 9 copy 1. Codes 10 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An effect bundle is presented this cycle |
| pcIn | input | 32 | Address of the presented instruction |
| rdAEn | input | 1 | Read register file into source 1 |
| rdAIdx | input | 5 | Entry for read port A |
| rdBEn | input | 1 | Read register file into source 2 |
| rdBIdx | input | 5 | Entry for read port B |
| wrEn | input | 1 | Write the register file |
| wrIdx | input | 5 | Entry to write |
| wrSel | input | 4 | Internal register written to the register file |
| aluEn | input | 1 | Perform an ALU operation |
| aluOp | input | 3 | ALU operation code |
| aluToRes2 | input | 1 | Send the ALU result to the second result register |
| aluSelA | input | 4 | ALU operand A selector |
| aluSelB | input | 4 | ALU operand B selector |
| mulEn | input | 1 | Start a multiply |
| mulSelA | input | 4 | Multiplicand selector |
| mulSelB | input | 4 | Multiplier selector |
| memEn | input | 1 | Perform a data memory access |
| memStore | input | 1 | Access is a store (else a load) |
| memAddrSel | input | 4 | Address selector |
| memDataSel | input | 4 | Store data selector |
| immEn | input | 1 | Write the sign-extend register |
| immForm | input | 2 | Immediate form |
| immVal | input | 16 | Immediate bits |
| tgtEn | input | 1 | Compute the branch target |
| seqEn | input | 1 | Save the sequential address |
| cpyEn | input | 1 | Perform a copy |
| cpyDst | input | 1 | Copy register written |
| cpySel | input | 4 | Copy source selector |
| ldRespValid | input | 1 | Load data is returned this cycle |
| ldRespData | input | 32 | Returned load data |
| stall | output | 1 | Presented instruction is abandoned this cycle |
| memReq | output | 1 | Data memory request |
| memWe | output | 1 | Request is a store |
| memAddr | output | 32 | Request address |
| memWdata | output | 32 | Store data |
| tgtOut | output | 32 | Target register |
| seqOut | output | 32 | Sequential register |

## Verification
The hardest collision is an instruction that carries ordinary effects (an immediate, a copy, a register file write, a target, a store) while it also consumes the running multiply's result. The bench issues a multiply, presents such a bundle for several stalled cycles, then withdraws it. After the multiply finishes, it reads back every register the bundle named and expects the pre-bundle values. A second pairing writes the sign-extend register and reads it in the same bundle through the ALU, the copy and the target effects. In that case the old value must reach all three consumers.

// File: rtl/xeu_pkg.sv
package xeu_pkg;
  localparam int XDW = 32;
  localparam int XRF_DEPTH = 32;
  localparam int XRF_AW = $clog2(XRF_DEPTH);
  localparam int XSEL_W = 4;
  localparam int XIMM_W = 16;
  localparam int XSMALL_W = 7;

  localparam logic [XSEL_W-1:0] SEL_SRC1 = 4'd0;
  localparam logic [XSEL_W-1:0] SEL_SRC2 = 4'd1;
  localparam logic [XSEL_W-1:0] SEL_LDV  = 4'd2;
  localparam logic [XSEL_W-1:0] SEL_SEX  = 4'd3;
  localparam logic [XSEL_W-1:0] SEL_ALUR = 4'd4;
  localparam logic [XSEL_W-1:0] SEL_RES2 = 4'd5;
  localparam logic [XSEL_W-1:0] SEL_TGT  = 4'd6;
  localparam logic [XSEL_W-1:0] SEL_SEQ  = 4'd7;
  localparam logic [XSEL_W-1:0] SEL_CPY0 = 4'd8;
  localparam logic [XSEL_W-1:0] SEL_CPY1 = 4'd9;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL, ALU_SRL, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {IMM_SMALL, IMM_LOW, IMM_HIGH, IMM_KEEP} imm_form_e;

  typedef struct packed {
    logic              rdAEn;
    logic [XRF_AW-1:0] rdAIdx;
    logic              rdBEn;
    logic [XRF_AW-1:0] rdBIdx;
    logic              wrEn;
    logic [XRF_AW-1:0] wrIdx;
    logic [XSEL_W-1:0] wrSel;
    logic              aluEn;
    alu_op_e           aluOp;
    logic              aluToRes2;
    logic [XSEL_W-1:0] aluSelA;
    logic [XSEL_W-1:0] aluSelB;
    logic              mulEn;
    logic [XSEL_W-1:0] mulSelA;
    logic [XSEL_W-1:0] mulSelB;
    logic              memEn;
    logic              memStore;
    logic [XSEL_W-1:0] memAddrSel;
    logic [XSEL_W-1:0] memDataSel;
    logic              immEn;
    imm_form_e         immForm;
    logic [XIMM_W-1:0] immVal;
    logic              tgtEn;
    logic              seqEn;
    logic              cpyEn;
    logic              cpyDst;
    logic [XSEL_W-1:0] cpySel;
  } effect_t;

  typedef struct packed {
    logic rdA;
    logic rdB;
    logic wr;
    logic alu;
    logic mulGo;
    logic memLd;
    logic memSt;
    logic imm;
    logic tgt;
    logic seq;
    logic cpy;
  } strobe_t;

  typedef struct packed {
    logic [XDW-1:0] src1;
    logic [XDW-1:0] src2;
    logic [XDW-1:0] ldv;
    logic [XDW-1:0] sex;
    logic [XDW-1:0] alur;
    logic [XDW-1:0] res2;
    logic [XDW-1:0] tgt;
    logic [XDW-1:0] seq;
    logic [XDW-1:0] cpy0;
    logic [XDW-1:0] cpy1;
  } ireg_t;
endpackage

// File: rtl/xeu_regfile.sv
module xeu_regfile #(
  parameter int DW = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAIdx,
  input  logic [AW-1:0] rdBIdx,
  input  logic          wrEn,
  input  logic [AW-1:0] wrIdx,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdAData,
  output logic [DW-1:0] rdBData
);
  logic [DW-1:0] mem [DEPTH];

  // reads see the contents before this cycle's write
  assign rdAData = mem[rdAIdx];
  assign rdBData = mem[rdBIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[wrIdx] <= wrData;
    end
  end
endmodule

// File: rtl/xeu_mul.sv
module xeu_mul #(
  parameter int DW = 32,
  parameter int STEPS = 32,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          go,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] mcand;
  logic [DW-1:0] mplier;
  logic [DW-1:0] acc;
  logic [DW-1:0] accNext;

  assign accNext = acc + (mplier[0] ? mcand : '0);
  assign done    = busy && (cnt == LAST);
  assign result  = accNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
    end else if (go) begin
      busy   <= 1'b1;
      cnt    <= '0;
      mcand  <= opA;
      mplier <= opB;
      acc    <= '0;
    end else if (busy) begin
      acc    <= accNext;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      cnt    <= cnt + CW'(1);
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  AST_MUL_START: assert property (@(posedge clk) disable iff (!rstN)
    go |=> busy); // R9
  AST_MUL_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt == LAST && !go) |=> !busy); // R9
endmodule

// File: rtl/xeu_ctrl.sv
module xeu_ctrl
  import xeu_pkg::*;
(
  input  logic    instValid,
  input  effect_t eff,
  input  logic    mulBusy,
  input  logic    ldPend,
  output strobe_t sb,
  output logic    stall
);
  function automatic logic usesSel(effect_t e, logic [XSEL_W-1:0] s);
    return (e.aluEn && (e.aluSelA == s || e.aluSelB == s)) ||
           (e.mulEn && (e.mulSelA == s || e.mulSelB == s)) ||
           (e.memEn && e.memAddrSel == s) ||
           (e.memEn && e.memStore && e.memDataSel == s) ||
           (e.wrEn && e.wrSel == s) ||
           (e.cpyEn && e.cpySel == s);
  endfunction

  logic mulHaz;
  logic ldHaz;
  logic commit;

  always_comb begin
    mulHaz = mulBusy && (usesSel(eff, SEL_RES2) || eff.mulEn ||
                         (eff.aluEn && eff.aluToRes2));
    ldHaz  = ldPend && (usesSel(eff, SEL_LDV) || (eff.memEn && !eff.memStore));
    stall  = instValid && (mulHaz || ldHaz);
    commit = instValid && !stall;

    sb.rdA   = commit && eff.rdAEn;
    sb.rdB   = commit && eff.rdBEn;
    sb.wr    = commit && eff.wrEn;
    sb.alu   = commit && eff.aluEn;
    sb.mulGo = commit && eff.mulEn;
    sb.memLd = commit && eff.memEn && !eff.memStore;
    sb.memSt = commit && eff.memEn && eff.memStore;
    sb.imm   = commit && eff.immEn;
    sb.tgt   = commit && eff.tgtEn;
    sb.seq   = commit && eff.seqEn;
    sb.cpy   = commit && eff.cpyEn;
  end
endmodule

// File: rtl/xeu_datapath.sv
module xeu_datapath
  import xeu_pkg::*;
#(
  parameter int MUL_STEPS = 32,
  parameter int PC_STEP = 4,
  localparam int SHW = $clog2(XDW)
) (
  input  logic           clk,
  input  logic           rstN,
  input  effect_t        eff,
  input  strobe_t        sb,
  input  logic [XDW-1:0] pcIn,
  input  logic           ldRespValid,
  input  logic [XDW-1:0] ldRespData,
  output logic           mulBusy,
  output logic           ldPend,
  output logic [XDW-1:0] memAddr,
  output logic [XDW-1:0] memWdata,
  output logic [XDW-1:0] tgtOut,
  output logic [XDW-1:0] seqOut
);
  ireg_t r;

  function automatic logic [XDW-1:0] pick(ireg_t v, logic [XSEL_W-1:0] s);
    case (s)
      SEL_SRC1: return v.src1;
      SEL_SRC2: return v.src2;
      SEL_LDV:  return v.ldv;
      SEL_SEX:  return v.sex;
      SEL_ALUR: return v.alur;
      SEL_RES2: return v.res2;
      SEL_TGT:  return v.tgt;
      SEL_SEQ:  return v.seq;
      SEL_CPY0: return v.cpy0;
      SEL_CPY1: return v.cpy1;
      default:  return '0;
    endcase
  endfunction

  logic [XDW-1:0] rdAData, rdBData, wrData;
  logic [XDW-1:0] aluA, aluB, aluY, immNext;
  logic           mulDone;
  logic [XDW-1:0] mulRes;

  assign wrData   = pick(r, eff.wrSel);
  assign memAddr  = pick(r, eff.memAddrSel);
  assign memWdata = pick(r, eff.memDataSel);
  assign aluA     = pick(r, eff.aluSelA);
  assign aluB     = pick(r, eff.aluSelB);
  assign tgtOut   = r.tgt;
  assign seqOut   = r.seq;

  xeu_regfile #(.DW(XDW), .DEPTH(XRF_DEPTH)) u_rf (
    .clk(clk), .rstN(rstN),
    .rdAIdx(eff.rdAIdx), .rdBIdx(eff.rdBIdx),
    .wrEn(sb.wr), .wrIdx(eff.wrIdx), .wrData(wrData),
    .rdAData(rdAData), .rdBData(rdBData)
  );

  xeu_mul #(.DW(XDW), .STEPS(MUL_STEPS)) u_mul (
    .clk(clk), .rstN(rstN), .go(sb.mulGo),
    .opA(pick(r, eff.mulSelA)), .opB(pick(r, eff.mulSelB)),
    .busy(mulBusy), .done(mulDone), .result(mulRes)
  );

  always_comb begin
    case (eff.aluOp)
      ALU_ADD: aluY = aluA + aluB;
      ALU_SUB: aluY = aluA - aluB;
      ALU_AND: aluY = aluA & aluB;
      ALU_OR:  aluY = aluA | aluB;
      ALU_XOR: aluY = aluA ^ aluB;
      ALU_SLL: aluY = aluA << aluB[SHW-1:0];
      ALU_SRL: aluY = aluA >> aluB[SHW-1:0];
      default: aluY = XDW'($signed(aluA) < $signed(aluB));
    endcase
  end

  always_comb begin
    case (eff.immForm)
      IMM_SMALL: immNext = {{(XDW-XSMALL_W){eff.immVal[XSMALL_W-1]}},
                            eff.immVal[XSMALL_W-1:0]};
      IMM_LOW:   immNext = {r.sex[XDW-1:XIMM_W], eff.immVal};
      IMM_HIGH:  immNext = {eff.immVal, r.sex[XDW-XIMM_W-1:0]};
      default:   immNext = r.sex;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      r      <= '0;
      ldPend <= 1'b0;
    end else begin
      if (sb.rdA) r.src1 <= rdAData;
      if (sb.rdB) r.src2 <= rdBData;
      if (ldRespValid && ldPend) r.ldv <= ldRespData;
      if (sb.memLd) ldPend <= 1'b1;
      else if (ldRespValid) ldPend <= 1'b0;
      if (sb.imm) r.sex <= immNext;
      if (sb.alu && !eff.aluToRes2) r.alur <= aluY;
      if (mulDone) r.res2 <= mulRes;
      else if (sb.alu && eff.aluToRes2) r.res2 <= aluY;
      if (sb.tgt) r.tgt <= pcIn + r.sex;
      if (sb.seq) r.seq <= pcIn + XDW'(PC_STEP);
      if (sb.cpy) begin
        if (eff.cpyDst) r.cpy1 <= pick(r, eff.cpySel);
        else            r.cpy0 <= pick(r, eff.cpySel);
      end
    end
  end

  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sb.tgt |=> $stable(r.tgt)); // R3
  AST_CPY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sb.cpy |=> ($stable(r.cpy0) && $stable(r.cpy1))); // R3
  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    sb.seq |=> (r.seq == $past(pcIn) + XDW'(PC_STEP))); // R6
  AST_MUL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    mulBusy |-> !sb.mulGo); // R9
  AST_LDV_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ldPend && !ldRespValid) |=> ldPend); // R10
endmodule

// File: rtl/exposed_exec_unit.sv
module exposed_exec_unit
  import xeu_pkg::*;
#(
  parameter int MUL_STEPS = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [XDW-1:0]    pcIn,
  input  logic              rdAEn,
  input  logic [XRF_AW-1:0] rdAIdx,
  input  logic              rdBEn,
  input  logic [XRF_AW-1:0] rdBIdx,
  input  logic              wrEn,
  input  logic [XRF_AW-1:0] wrIdx,
  input  logic [XSEL_W-1:0] wrSel,
  input  logic              aluEn,
  input  logic [2:0]        aluOp,
  input  logic              aluToRes2,
  input  logic [XSEL_W-1:0] aluSelA,
  input  logic [XSEL_W-1:0] aluSelB,
  input  logic              mulEn,
  input  logic [XSEL_W-1:0] mulSelA,
  input  logic [XSEL_W-1:0] mulSelB,
  input  logic              memEn,
  input  logic              memStore,
  input  logic [XSEL_W-1:0] memAddrSel,
  input  logic [XSEL_W-1:0] memDataSel,
  input  logic              immEn,
  input  logic [1:0]        immForm,
  input  logic [XIMM_W-1:0] immVal,
  input  logic              tgtEn,
  input  logic              seqEn,
  input  logic              cpyEn,
  input  logic              cpyDst,
  input  logic [XSEL_W-1:0] cpySel,
  input  logic              ldRespValid,
  input  logic [XDW-1:0]    ldRespData,
  output logic              stall,
  output logic              memReq,
  output logic              memWe,
  output logic [XDW-1:0]    memAddr,
  output logic [XDW-1:0]    memWdata,
  output logic [XDW-1:0]    tgtOut,
  output logic [XDW-1:0]    seqOut
);
  effect_t eff;
  strobe_t sb;
  logic    mulBusy;
  logic    ldPend;

  always_comb begin
    eff.rdAEn      = rdAEn;
    eff.rdAIdx     = rdAIdx;
    eff.rdBEn      = rdBEn;
    eff.rdBIdx     = rdBIdx;
    eff.wrEn       = wrEn;
    eff.wrIdx      = wrIdx;
    eff.wrSel      = wrSel;
    eff.aluEn      = aluEn;
    eff.aluOp      = alu_op_e'(aluOp);
    eff.aluToRes2  = aluToRes2;
    eff.aluSelA    = aluSelA;
    eff.aluSelB    = aluSelB;
    eff.mulEn      = mulEn;
    eff.mulSelA    = mulSelA;
    eff.mulSelB    = mulSelB;
    eff.memEn      = memEn;
    eff.memStore   = memStore;
    eff.memAddrSel = memAddrSel;
    eff.memDataSel = memDataSel;
    eff.immEn      = immEn;
    eff.immForm    = imm_form_e'(immForm);
    eff.immVal     = immVal;
    eff.tgtEn      = tgtEn;
    eff.seqEn      = seqEn;
    eff.cpyEn      = cpyEn;
    eff.cpyDst     = cpyDst;
    eff.cpySel     = cpySel;
  end

  xeu_ctrl u_ctrl (
    .instValid(instValid), .eff(eff), .mulBusy(mulBusy), .ldPend(ldPend),
    .sb(sb), .stall(stall)
  );

  xeu_datapath #(.MUL_STEPS(MUL_STEPS), .PC_STEP(PC_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .eff(eff), .sb(sb), .pcIn(pcIn),
    .ldRespValid(ldRespValid), .ldRespData(ldRespData),
    .mulBusy(mulBusy), .ldPend(ldPend),
    .memAddr(memAddr), .memWdata(memWdata), .tgtOut(tgtOut), .seqOut(seqOut)
  );

  assign memReq = sb.memLd || sb.memSt;
  assign memWe  = sb.memSt;

  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !memReq); // R11
  AST_ONE_LOAD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && !ldRespValid) |=> !(memReq && !memWe)); // R10
endmodule

// File: tb/sim_exposed_exec_unit.sv
`timescale 1ns/1ps
module sim_exposed_exec_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, instValid;
  logic [31:0] pcIn;
  logic rdAEn, rdBEn, wrEn, aluEn, aluToRes2, mulEn, memEn, memStore;
  logic immEn, tgtEn, seqEn, cpyEn, cpyDst, ldRespValid;
  logic [4:0] rdAIdx, rdBIdx, wrIdx;
  logic [3:0] wrSel, aluSelA, aluSelB, mulSelA, mulSelB, memAddrSel, memDataSel, cpySel;
  logic [2:0] aluOp;
  logic [1:0] immForm;
  logic [15:0] immVal;
  logic [31:0] ldRespData;
  logic stall, memReq, memWe;
  logic [31:0] memAddr, memWdata, tgtOut, seqOut;

  exposed_exec_unit u0 (.*);

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  localparam int NV = 8;
  localparam logic [2:0]  V_OP [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic [31:0] V_A  [NV] = '{32'h7FFF_FFFF, 32'd5, 32'hF0F0_1234, 32'hF000_0000,
                                        32'hAAAA_5555, 32'd3, 32'h8000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] V_B  [NV] = '{32'd1, 32'd7, 32'h0FF0_FF00, 32'h0000_000F,
                                        32'hFFFF_0000, 32'd4, 32'd31, 32'd1};
  localparam logic [31:0] V_Y  [NV] = '{32'h8000_0000, 32'hFFFF_FFFE, 32'h00F0_1200, 32'hF000_000F,
                                        32'h5555_5555, 32'h30, 32'd1, 32'd1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    instValid = 0; pcIn = 32'h100;
    rdAEn = 0; rdAIdx = 0; rdBEn = 0; rdBIdx = 0; wrEn = 0; wrIdx = 0; wrSel = 0;
    aluEn = 0; aluOp = 0; aluToRes2 = 0; aluSelA = 0; aluSelB = 0;
    mulEn = 0; mulSelA = 0; mulSelB = 0;
    memEn = 0; memStore = 0; memAddrSel = 0; memDataSel = 0;
    immEn = 0; immForm = 0; immVal = 0; tgtEn = 0; seqEn = 0;
    cpyEn = 0; cpyDst = 0; cpySel = 0; ldRespValid = 0; ldRespData = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fire();
    tick(); idle();
  endtask

  task automatic storeChk(input logic [3:0] sel, input logic [31:0] exp, input string tag);
    idle(); instValid = 1; memEn = 1; memStore = 1; memDataSel = sel; memAddrSel = sel;
    @(negedge clk);
    chk({tag, " store request"}, {31'b0, memReq && memWe}, 32'd1);
    chk(tag, memWdata, exp);
    fire();
  endtask

  task automatic setSex(input logic [31:0] v);
    idle(); instValid = 1; immEn = 1; immForm = 2; immVal = v[31:16]; tick();
    immForm = 1; immVal = v[15:0]; fire();
  endtask

  task automatic copyTo(input logic dst, input logic [3:0] sel);
    idle(); instValid = 1; cpyEn = 1; cpyDst = dst; cpySel = sel; fire();
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      nBad++; nChk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int nStall;
    idle(); rstN = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state
    @(negedge clk);
    chk("R1 tgtOut", tgtOut, 0);
    chk("R1 seqOut", seqOut, 0);
    chk("R1 stall", {31'b0, stall}, 0);
    chk("R1 memReq idle", {31'b0, memReq}, 0);
    tick();
    for (int s = 0; s < 10; s++) storeChk(4'(s), 32'd0, $sformatf("R1 internal reg sel %0d", s));
    storeChk(4'd12, 32'd0, "R12 unused selector");

    // R4 / R12: ALU vector table, results alternate destination
    for (int i = 0; i < NV; i++) begin
      setSex(V_A[i]);
      copyTo(1'b0, 4'd3);
      setSex(V_B[i]);
      idle(); instValid = 1; aluEn = 1; aluOp = V_OP[i]; aluToRes2 = i[0];
      aluSelA = 4'd8; aluSelB = 4'd3; fire();
      storeChk(i[0] ? 4'd5 : 4'd4, V_Y[i], $sformatf("R4 alu vector %0d", i));
    end

    // R5: immediate forms
    idle(); instValid = 1; immEn = 1; immForm = 0; immVal = 16'h0040; fire();
    storeChk(4'd3, 32'hFFFF_FFC0, "R5 small negative");
    idle(); instValid = 1; immEn = 1; immForm = 0; immVal = 16'hFF3F; fire();
    storeChk(4'd3, 32'h0000_003F, "R5 small positive");
    idle(); instValid = 1; immEn = 1; immForm = 2; immVal = 16'hDEAD; fire();
    storeChk(4'd3, 32'hDEAD_003F, "R5 high half");
    idle(); instValid = 1; immEn = 1; immForm = 1; immVal = 16'hBEEF; fire();
    storeChk(4'd3, 32'hDEAD_BEEF, "R5 low half");

    // R7: copy
    copyTo(1'b1, 4'd3);
    storeChk(4'd9, 32'hDEAD_BEEF, "R7 copy register 1");

    // R6: target and sequential
    setSex(32'hFFFF_FFF8);
    idle(); instValid = 1; pcIn = 32'h1000; tgtEn = 1; seqEn = 1; fire();
    @(negedge clk);
    chk("R6 tgtOut", tgtOut, 32'h0000_0FF8);
    chk("R6 seqOut", seqOut, 32'h0000_1004);
    tick();
    storeChk(4'd6, 32'h0000_0FF8, "R6 target via selector");
    storeChk(4'd7, 32'h0000_1004, "R6 sequential via selector");

    // R8: same-cycle write and reads of the sign-extend register
    idle(); instValid = 1; pcIn = 32'h2000; immEn = 1; immForm = 0; immVal = 16'd5;
    aluEn = 1; aluOp = 0; aluSelA = 4'd3; aluSelB = 4'd3;
    cpyEn = 1; cpyDst = 0; cpySel = 4'd3; tgtEn = 1; fire();
    storeChk(4'd4, 32'hFFFF_FFF0, "R8 alu saw old value");
    storeChk(4'd8, 32'hFFFF_FFF8, "R8 copy saw old value");
    storeChk(4'd3, 32'd5, "R8 new immediate");
    @(negedge clk);
    chk("R8 target saw old value", tgtOut, 32'h0000_1FF8);
    tick();

    // R3: hold across idle cycles and unrelated effects
    for (int k = 0; k < 20; k++) begin
      idle(); pcIn = 32'h4000 + 32'(k); tick();
    end
    idle(); instValid = 1; aluEn = 1; aluOp = 4; aluSelA = 4'd3; aluSelB = 4'd3; fire();
    @(negedge clk);
    chk("R3 tgtOut held", tgtOut, 32'h0000_1FF8);
    chk("R3 seqOut held", seqOut, 32'h0000_1004);
    tick();
    storeChk(4'd9, 32'hDEAD_BEEF, "R3 copy register 1 held");

    // R2: register file, same-cycle write/read returns old value
    idle(); instValid = 1; wrEn = 1; wrIdx = 5'd5; wrSel = 4'd3; rdAEn = 1; rdAIdx = 5'd5; fire();
    storeChk(4'd0, 32'd0, "R2 read during write is old");
    idle(); instValid = 1; rdAEn = 1; rdAIdx = 5'd5; rdBEn = 1; rdBIdx = 5'd5; fire();
    storeChk(4'd0, 32'd5, "R2 port A after write");
    storeChk(4'd1, 32'd5, "R2 port B after write");

    // R9: multiply latency, stall only on consumers
    setSex(32'd7);
    copyTo(1'b0, 4'd3);
    setSex(32'h0001_2345);
    idle(); instValid = 1; mulEn = 1; mulSelA = 4'd8; mulSelB = 4'd3; fire();
    idle(); instValid = 1; aluEn = 1; aluOp = 0; aluSelA = 4'd3; aluSelB = 4'd3;
    @(negedge clk);
    chk("R9 unrelated instruction no stall", {31'b0, stall}, 0);
    fire();
    nStall = 0;
    idle(); instValid = 1; memEn = 1; memStore = 1; memDataSel = 4'd5; memAddrSel = 4'd5;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!stall) break;
      nStall++;
      if (memReq) chk("R11 request while stalled", 1, 0);
      tick();
    end
    chk("R9 stall cycles", 32'(nStall), 32'd31);
    chk("R9 product", memWdata, 32'h0007_F6E3);
    fire();
    storeChk(4'd4, 32'h0002_468A, "R9 alu during multiply");

    // R11: abandoned bundle leaves no trace
    idle(); instValid = 1; mulEn = 1; mulSelA = 4'd8; mulSelB = 4'd3; fire();
    idle(); instValid = 1; pcIn = 32'h3000;
    aluEn = 1; aluOp = 0; aluSelA = 4'd5; aluSelB = 4'd3;
    immEn = 1; immForm = 0; immVal = 16'h0055;
    wrEn = 1; wrIdx = 5'd9; wrSel = 4'd3;
    cpyEn = 1; cpyDst = 1; cpySel = 4'd3;
    tgtEn = 1; seqEn = 1; memEn = 1; memStore = 1; memDataSel = 4'd3; memAddrSel = 4'd3;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 bundle stalled", {31'b0, stall}, 1);
      chk("R11 no request", {31'b0, memReq}, 0);
      tick();
    end
    idle();
    repeat (40) tick();
    storeChk(4'd3, 32'h0001_2345, "R11 sign extend untouched");
    storeChk(4'd9, 32'hDEAD_BEEF, "R11 copy untouched");
    storeChk(4'd4, 32'h0002_468A, "R11 alu result untouched");
    @(negedge clk);
    chk("R11 target untouched", tgtOut, 32'h0000_1FF8);
    chk("R11 sequential untouched", seqOut, 32'h0000_1004);
    tick();
    idle(); instValid = 1; rdAEn = 1; rdAIdx = 5'd9; fire();
    storeChk(4'd0, 32'd0, "R11 register file untouched");

    // R10: load request and pending load value
    setSex(32'h40);
    idle(); instValid = 1; memEn = 1; memStore = 0; memAddrSel = 4'd3;
    @(negedge clk);
    chk("R10 load request", {31'b0, memReq}, 1);
    chk("R10 load not write", {31'b0, memWe}, 0);
    chk("R10 load address", memAddr, 32'h40);
    fire();
    idle(); instValid = 1; memEn = 1; memStore = 1; memDataSel = 4'd2; memAddrSel = 4'd3;
    ldRespValid = 1; ldRespData = 32'hCAFE_F00D;
    @(negedge clk);
    chk("R10 stall on pending value", {31'b0, stall}, 1);
    tick();
    ldRespValid = 0;
    @(negedge clk);
    chk("R10 released", {31'b0, stall}, 0);
    chk("R10 load value", memWdata, 32'hCAFE_F00D);
    fire();

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule